// File: doc/BRIEF.md
# Serial Transmitter with Per-Frame Completion Actions

This block is an asynchronous serial transmitter whose queued frames each carry their own side effects. One bus write of a 32-bit word places two frames in a four-entry transmit queue. Each frame holds up to nine data bits and five action flags. The transmitter sends queued frames in order. Each frame has one start bit, eight or nine data bits sent least significant bit first, and one stop bit. Bit timing comes from a baud-tick input, with sixteen ticks per bit.

When a frame's stop bit ends, the block applies the flags that travelled with that frame. A flag can turn on the receiver, turn off the transmitter and release the line, mark the output as tristated, or remove the receiver block. A frame can also be sent as a break: its data bit times are forced low. This lets software queue a reply and state in the same write what the link does once the reply has left the wire. A typical use is a half-duplex turnaround.

Top module: `uart_xact_tx`

## Requirements
- R1: After reset, txd_o is 1 and txd_oe_o, tx_en_o, rx_en_o, tx_tri_o, rx_block_o, tx_done_o and ovf_o are 0, and level_o is 0.
- R2: A pulse on wr_dbl_i enqueues two frames from wr_word_i. The first frame takes its data from bits 8:0 and the second from bits 24:16. The first frame is transmitted before the second.
- R3: A frame is sent as a start bit at 0, then the data bits LSB first, then a stop bit at 1. Each bit lasts 16 baud ticks. The data is 9 bits when nine_bit_i is 1 and 8 bits when it is 0; in 8-bit mode, data bit 8 is not sent. The line idles at 1.
- R4: Flag bits 13 (first frame) and 29 (second frame) select a break. The data bit times of that frame are sent as 0 whatever its data, and the stop bit is still 1.
- R5: tx_done_o pulses high for exactly one cycle. It rises in the cycle after the stop bit's last baud tick, and the frame's actions take effect in that same cycle.
- R6: Flag bits 15 and 31 set rx_en_o to 1 when their frame completes.
- R7: Flag bits 14 and 30 clear tx_en_o and txd_oe_o when their frame completes. Frames still queued are then held until tx_en_o is set again.
- R8: Flag bits 12 and 28 set tx_tri_o to 1 and drive txd_oe_o to 0 when their frame completes.
- R9: Flag bits 11 and 27 clear rx_block_o when their frame completes. A pulse on rxblk_set_i sets rx_block_o.
- R10: A double write made while fewer than two queue entries are free is dropped whole: ovf_o pulses for one cycle and level_o does not grow. The free count is taken before any pop in the same cycle.
- R11: Bits 10:9 and 26:25 of wr_word_i are ignored. They change neither the frames sent nor any status output.
- R12: No frame starts while tx_en_o is 0. A pulse on txen_set_i sets tx_en_o and clears tx_tri_o. txd_oe_o equals tx_en_o and not tx_tri_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| baud_tick_i | input | 1 | One-cycle tick, 16 per bit time |
| nine_bit_i | input | 1 | 1 selects 9 data bits, 0 selects 8; sampled at frame start |
| wr_dbl_i | input | 1 | Double-frame write strobe |
| wr_word_i | input | 32 | Double-frame write data with flags |
| txen_set_i | input | 1 | Sets the transmit enable and clears the tristate status |
| rxblk_set_i | input | 1 | Sets the receiver-block status |
| txd_o | output | 1 | Serial data line |
| txd_oe_o | output | 1 | Output enable for the data line |
| tx_en_o | output | 1 | Transmit enable status |
| rx_en_o | output | 1 | Receiver enable |
| tx_tri_o | output | 1 | Tristate status |
| rx_block_o | output | 1 | Receiver-block status |
| tx_done_o | output | 1 | One-cycle pulse at frame completion |
| ovf_o | output | 1 | One-cycle pulse when a double write is dropped |
| level_o | output | 3 | Number of queued frames |

## Verification
The bench loads a double write while the transmitter is off and checks that the low half leaves first. A design that swapped the halves, or that started sending without the enable, would emit the wrong first frame or any frame at all. Break frames with all-ones data, 8-bit mode with data bit 8 set, and reserved bits set are each compared bit by bit at mid-bit. A leaked data bit or a stray status change then shows up directly. Each action flag is checked in the exact cycle of the done pulse, against the value one cycle earlier, so an action applied late, early or to the wrong frame is caught. A clear-enable frame with a second frame behind it, followed by a write into a queue with one free slot, tests that the held frame stays put and that the partial write is dropped rather than half accepted.

// File: rtl/uxt_pkg.sv
package uxt_pkg;

    localparam int DATA_W = 9;

    // one queued frame: action flags travel with the data
    typedef struct packed {
        logic              rx_en_after;
        logic              tx_dis_after;
        logic              brk;
        logic              tri_after;
        logic              unblk_after;
        logic [DATA_W-1:0] data;
    } tx_entry_t;

    // one 16-bit half of the double-write word; bits 10:9 are not decoded
    function automatic tx_entry_t unpack_half(input logic [15:0] h);
        tx_entry_t e;
        e.data         = h[8:0];
        e.unblk_after  = h[11];
        e.tri_after    = h[12];
        e.brk          = h[13];
        e.tx_dis_after = h[14];
        e.rx_en_after  = h[15];
        return e;
    endfunction

endpackage

// File: rtl/uxt_fifo.sv
module uxt_fifo
    import uxt_pkg::*;
#(
    parameter int DEPTH = 4,        // power of two
    localparam int PW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          push2_i,
    input  tx_entry_t     ent0_i,
    input  tx_entry_t     ent1_i,
    input  logic          pop_i,
    output tx_entry_t     head_o,
    output logic [CW-1:0] level_o,
    output logic          drop_o
);

    typedef struct packed {
        tx_entry_t [DEPTH-1:0] mem;
        logic [PW-1:0]         wptr;
        logic [PW-1:0]         rptr;
        logic [CW-1:0]         count;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic     accept;
    logic     do_pop;

    always_comb begin
        st_d   = st_q;
        accept = push2_i && ((CW'(DEPTH) - st_q.count) >= CW'(2));
        do_pop = pop_i && (st_q.count != '0);
        drop_o = push2_i && !accept;
        if (do_pop) begin
            st_d.rptr = PW'(st_q.rptr + PW'(1));
        end
        if (accept) begin
            st_d.mem[st_q.wptr]                   = ent0_i;
            st_d.mem[PW'(st_q.wptr + PW'(1))]     = ent1_i;
            st_d.wptr                             = PW'(st_q.wptr + PW'(2));
        end
        st_d.count = CW'(st_q.count + (accept ? CW'(2) : CW'(0)) - (do_pop ? CW'(1) : CW'(0)));
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign head_o  = st_q.mem[st_q.rptr];
    assign level_o = st_q.count;

    // R10
    no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        level_o <= CW'(DEPTH));

    // R10
    drop_keeps_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (drop_o && !pop_i) |=> (level_o == $past(level_o)));

    // R12
    pop_nonempty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pop_i |-> (level_o != '0));

endmodule

// File: rtl/uxt_shifter.sv
module uxt_shifter
    import uxt_pkg::*;
#(
    parameter int TICKS_PER_BIT = 16,
    localparam int TW = (TICKS_PER_BIT > 1) ? $clog2(TICKS_PER_BIT) : 1,
    localparam int IW = $clog2(DATA_W + 1)
) (
    input  logic      clk_i,
    input  logic      rst_ni,
    input  logic      baud_tick_i,
    input  logic      start_i,
    input  tx_entry_t frame_i,
    input  logic      nine_bit_i,
    output logic      busy_o,
    output logic      txd_o,
    output logic      end_o,
    output tx_entry_t cur_o
);

    typedef enum logic [1:0] {S_IDLE, S_START, S_DATA, S_STOP} sh_state_e;

    typedef struct packed {
        sh_state_e         st;
        logic [TW-1:0]     tcnt;
        logic [IW-1:0]     sent;
        logic [IW-1:0]     nbits;
        logic [DATA_W-1:0] shreg;
        tx_entry_t         cur;
        logic              txd;
    } sh_t;

    sh_t  sh_d, sh_q;
    logic last_tick;

    always_comb begin
        sh_d      = sh_q;
        end_o     = 1'b0;
        last_tick = baud_tick_i && (sh_q.tcnt == TW'(TICKS_PER_BIT - 1));
        if (baud_tick_i && sh_q.st != S_IDLE) begin
            sh_d.tcnt = last_tick ? '0 : TW'(sh_q.tcnt + TW'(1));
        end
        unique case (sh_q.st)
            S_IDLE: begin
                if (start_i) begin
                    sh_d.st    = S_START;
                    sh_d.tcnt  = '0;
                    sh_d.sent  = '0;
                    sh_d.cur   = frame_i;
                    sh_d.shreg = frame_i.brk ? '0 : frame_i.data;
                    sh_d.nbits = nine_bit_i ? IW'(DATA_W) : IW'(DATA_W - 1);
                    sh_d.txd   = 1'b0;
                end
            end
            S_START: begin
                if (last_tick) begin
                    sh_d.st    = S_DATA;
                    sh_d.txd   = sh_q.shreg[0];
                    sh_d.shreg = sh_q.shreg >> 1;
                    sh_d.sent  = IW'(1);
                end
            end
            S_DATA: begin
                if (last_tick) begin
                    if (sh_q.sent == sh_q.nbits) begin
                        sh_d.st  = S_STOP;
                        sh_d.txd = 1'b1;
                    end else begin
                        sh_d.txd   = sh_q.shreg[0];
                        sh_d.shreg = sh_q.shreg >> 1;
                        sh_d.sent  = IW'(sh_q.sent + IW'(1));
                    end
                end
            end
            S_STOP: begin
                if (last_tick) begin
                    sh_d.st  = S_IDLE;
                    sh_d.txd = 1'b1;
                    end_o    = 1'b1;
                end
            end
            default: sh_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            sh_q     <= '0;
            sh_q.txd <= 1'b1;
        end else begin
            sh_q <= sh_d;
        end
    end

    assign busy_o = (sh_q.st != S_IDLE);
    assign txd_o  = sh_q.txd;
    assign cur_o  = sh_q.cur;

    // R3
    idle_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sh_q.st == S_IDLE) |-> txd_o);

    // R3
    start_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sh_q.st == S_START) |-> !txd_o);

    // R4
    break_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sh_q.st == S_DATA && sh_q.cur.brk) |-> !txd_o);

    // R3
    stop_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sh_q.st == S_STOP) |-> txd_o);

endmodule

// File: rtl/uart_xact_tx.sv
module uart_xact_tx
    import uxt_pkg::*;
#(
    parameter int FIFO_DEPTH    = 4,
    parameter int TICKS_PER_BIT = 16,
    localparam int LW = $clog2(FIFO_DEPTH + 1)
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          baud_tick_i,
    input  logic          nine_bit_i,
    input  logic          wr_dbl_i,
    input  logic [31:0]   wr_word_i,
    input  logic          txen_set_i,
    input  logic          rxblk_set_i,
    output logic          txd_o,
    output logic          txd_oe_o,
    output logic          tx_en_o,
    output logic          rx_en_o,
    output logic          tx_tri_o,
    output logic          rx_block_o,
    output logic          tx_done_o,
    output logic          ovf_o,
    output logic [LW-1:0] level_o
);

    typedef struct packed {
        logic tx_en;
        logic rx_en;
        logic tri_st;
        logic rx_blk;
        logic done;
        logic ovf;
    } ctl_t;

    ctl_t      ctl_d, ctl_q;
    tx_entry_t head, cur, ent0, ent1;
    logic      busy, frame_end, start, drop, sh_txd;

    assign ent0 = unpack_half(wr_word_i[15:0]);
    assign ent1 = unpack_half(wr_word_i[31:16]);

    uxt_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .push2_i (wr_dbl_i),
        .ent0_i  (ent0),
        .ent1_i  (ent1),
        .pop_i   (start),
        .head_o  (head),
        .level_o (level_o),
        .drop_o  (drop)
    );

    uxt_shifter #(.TICKS_PER_BIT(TICKS_PER_BIT)) u_shifter (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .baud_tick_i (baud_tick_i),
        .start_i     (start),
        .frame_i     (head),
        .nine_bit_i  (nine_bit_i),
        .busy_o      (busy),
        .txd_o       (sh_txd),
        .end_o       (frame_end),
        .cur_o       (cur)
    );

    assign start = !busy && ctl_q.tx_en && (level_o != '0);

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = frame_end;
        ctl_d.ovf  = drop;
        if (txen_set_i) begin
            ctl_d.tx_en  = 1'b1;
            ctl_d.tri_st = 1'b0;
        end
        if (rxblk_set_i) begin
            ctl_d.rx_blk = 1'b1;
        end
        // completion actions of the finishing frame win over set inputs
        if (frame_end) begin
            if (cur.rx_en_after)  ctl_d.rx_en  = 1'b1;
            if (cur.tx_dis_after) ctl_d.tx_en  = 1'b0;
            if (cur.tri_after)    ctl_d.tri_st = 1'b1;
            if (cur.unblk_after)  ctl_d.rx_blk = 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign txd_o      = sh_txd;
    assign txd_oe_o   = ctl_q.tx_en && !ctl_q.tri_st;
    assign tx_en_o    = ctl_q.tx_en;
    assign rx_en_o    = ctl_q.rx_en;
    assign tx_tri_o   = ctl_q.tri_st;
    assign rx_block_o = ctl_q.rx_blk;
    assign tx_done_o  = ctl_q.done;
    assign ovf_o      = ctl_q.ovf;

    // R5
    done_follows_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        frame_end |=> tx_done_o);

    // R5
    done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tx_done_o |=> !tx_done_o);

    // R12
    hold_when_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!tx_en_o && !busy) |=> !busy);

    // R8
    tri_releases_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tx_tri_o |-> !txd_oe_o);

    // R7
    txdis_applies_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (frame_end && cur.tx_dis_after) |=> !tx_en_o);

endmodule

// File: tb/uart_xact_tx_tb_top.sv
module uart_xact_tx_tb_top;

    typedef struct {
        logic [8:0] data;
        bit         brk;
        bit         nine;
    } exp_item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        baud_tick = 1'b0;
    logic        nine_bit = 1'b0;
    logic        wr_dbl = 1'b0;
    logic [31:0] wr_word = '0;
    logic        txen_set = 1'b0;
    logic        rxblk_set = 1'b0;
    logic        txd, txd_oe, tx_en, rx_en, tx_tri, rx_block, tx_done, ovf;
    logic [2:0]  level;

    int checks = 0;
    int failures = 0;
    int frames_seen = 0;
    bit finished = 0;
    exp_item_t exp_q[$];

    // done-cycle snapshots
    logic pre_rx_en, pre_tx_en, pre_tri, pre_rx_block;

    always #5 clk = ~clk;

    uart_xact_tx dut_i (
        .clk_i(clk), .rst_ni(rst_n), .baud_tick_i(baud_tick), .nine_bit_i(nine_bit),
        .wr_dbl_i(wr_dbl), .wr_word_i(wr_word), .txen_set_i(txen_set),
        .rxblk_set_i(rxblk_set), .txd_o(txd), .txd_oe_o(txd_oe), .tx_en_o(tx_en),
        .rx_en_o(rx_en), .tx_tri_o(tx_tri), .rx_block_o(rx_block), .tx_done_o(tx_done),
        .ovf_o(ovf), .level_o(level)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    // baud tick every other clock
    initial begin
        forever begin
            @(negedge clk);
            baud_tick = ~baud_tick;
        end
    end

    // driver: one double write, expected frames pushed to the scoreboard
    task automatic dbl_write(input logic [31:0] w, input bit expect_drop);
        @(negedge clk);
        wr_word = w;
        wr_dbl  = 1'b1;
        @(negedge clk);
        wr_dbl  = 1'b0;
        wr_word = '0;
        check(ovf == expect_drop, "R10", "overflow pulse", ovf, expect_drop);
        if (!expect_drop) begin
            exp_q.push_back('{data: w[8:0],   brk: w[13], nine: nine_bit});
            exp_q.push_back('{data: w[24:16], brk: w[29], nine: nine_bit});
        end
    endtask

    task automatic pulse_txen();
        @(negedge clk); txen_set = 1'b1;
        @(negedge clk); txen_set = 1'b0;
    endtask

    task automatic pulse_rxblk();
        @(negedge clk); rxblk_set = 1'b1;
        @(negedge clk); rxblk_set = 1'b0;
    endtask

    // waits for a done pulse; snapshots status one cycle earlier
    task automatic wait_done();
        int t;
        t = 0;
        pre_rx_en = rx_en; pre_tx_en = tx_en; pre_tri = tx_tri; pre_rx_block = rx_block;
        @(negedge clk);
        while (!tx_done && t < 4000) begin
            pre_rx_en = rx_en; pre_tx_en = tx_en; pre_tri = tx_tri; pre_rx_block = rx_block;
            @(negedge clk);
            t++;
        end
        check(tx_done == 1'b1, "R5", "done pulse seen", tx_done, 1);
        fork
            begin
                @(negedge clk);
                check(tx_done == 1'b0, "R5", "done is one cycle wide", tx_done, 0);
            end
        join_none
    endtask

    // monitor: mid-bit sampling, compared against the scoreboard queue
    initial begin
        logic       prev;
        logic [8:0] got;
        logic [8:0] expv;
        exp_item_t  it;
        int         nb;
        prev = 1'b1;
        wait (rst_n);
        forever begin
            @(negedge clk);
            if (prev && !txd) begin
                repeat (15) @(negedge clk);
                check(txd == 1'b0, "R3", "start bit low", txd, 0);
                if (exp_q.size() == 0) begin
                    check(1'b0, "R12", "frame with nothing expected", 1, 0);
                    it = '{data: '0, brk: 1'b0, nine: 1'b0};
                end else begin
                    it = exp_q.pop_front();
                end
                nb  = it.nine ? 9 : 8;
                got = '0;
                for (int k = 0; k < nb; k++) begin
                    repeat (32) @(negedge clk);
                    got[k] = txd;
                end
                repeat (32) @(negedge clk);
                check(txd == 1'b1, "R3", "stop bit high", txd, 1);
                expv = it.brk ? 9'd0 : (it.nine ? it.data : {1'b0, it.data[7:0]});
                check(got == expv, it.brk ? "R4" : "R2", "frame data", got, expv);
                frames_seen++;
            end
            prev = txd;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(txd == 1'b1 && txd_oe == 1'b0 && tx_en == 1'b0, "R1", "line/enable after reset",
              {txd, txd_oe, tx_en}, 3'b100);
        check({rx_en, tx_tri, rx_block, tx_done, ovf} == 5'b0, "R1", "status after reset",
              {rx_en, tx_tri, rx_block, tx_done, ovf}, 0);
        check(level == 3'd0, "R1", "level after reset", level, 0);

        // R12 / R2: queue while disabled, nothing starts
        nine_bit = 1'b0;
        dbl_write(32'h01C3_005A, 1'b0);
        check(level == 3'd2, "R2", "two entries queued", level, 2);
        repeat (100) @(negedge clk);
        check(frames_seen == 0 && txd == 1'b1, "R12", "no start while disabled", frames_seen, 0);
        pulse_txen();
        check(tx_en == 1'b1 && txd_oe == 1'b1, "R12", "enable set", {tx_en, txd_oe}, 2'b11);
        wait_done();
        wait_done();
        check(frames_seen == 2, "R2", "both frames sent", frames_seen, 2);

        // R6 / R11: nine-bit, receive-enable flag, reserved bits set
        nine_bit = 1'b1;
        dbl_write(32'h06F0_81A5 | 32'h0000_0600, 1'b0);
        wait_done();
        check(pre_rx_en == 1'b0 && rx_en == 1'b1, "R6", "rx enable at done",
              {pre_rx_en, rx_en}, 2'b01);
        wait_done();
        check(tx_en == 1'b1 && tx_tri == 1'b0 && rx_block == 1'b0, "R11",
              "reserved bits change no status", {tx_en, tx_tri, rx_block}, 3'b100);

        // R4: break frame then normal frame
        nine_bit = 1'b0;
        dbl_write(32'h0033_20FF, 1'b0);
        wait_done();
        wait_done();

        // R9: unblock receiver
        pulse_rxblk();
        check(rx_block == 1'b1, "R9", "block set", rx_block, 1);
        dbl_write(32'h0022_0811, 1'b0);
        wait_done();
        check(pre_rx_block == 1'b1 && rx_block == 1'b0, "R9", "unblock at done",
              {pre_rx_block, rx_block}, 2'b10);
        wait_done();

        // R8: tristate after first frame
        dbl_write(32'h0066_1044, 1'b0);
        wait_done();
        check(pre_tri == 1'b0 && tx_tri == 1'b1 && txd_oe == 1'b0, "R8", "tristate at done",
              {pre_tri, tx_tri, txd_oe}, 3'b010);
        wait_done();
        pulse_txen();
        check(tx_tri == 1'b0 && txd_oe == 1'b1, "R12", "enable clears tristate",
              {tx_tri, txd_oe}, 2'b01);

        // R7: clear enable holds the second frame
        dbl_write(32'h0088_4077, 1'b0);
        wait_done();
        check(pre_tx_en == 1'b1 && tx_en == 1'b0 && txd_oe == 1'b0, "R7", "enable cleared at done",
              {pre_tx_en, tx_en, txd_oe}, 3'b100);
        repeat (400) @(negedge clk);
        check(level == 3'd1 && frames_seen == 11, "R7", "second frame held",
              {level, 8'(frames_seen)}, {3'd1, 8'd11});

        // R10: one free entry left -> double write dropped
        dbl_write(32'h00AA_0099, 1'b0);
        check(level == 3'd3, "R10", "level after fill", level, 3);
        dbl_write(32'h00CC_00BB, 1'b1);
        check(level == 3'd3, "R10", "level unchanged on drop", level, 3);
        @(negedge clk);
        check(ovf == 1'b0, "R10", "overflow is a pulse", ovf, 0);
        pulse_txen();
        wait_done();
        wait_done();
        wait_done();
        repeat (100) @(negedge clk);
        check(frames_seen == 14 && exp_q.size() == 0, "R2", "all frames in order",
              frames_seen, 14);
        check(level == 3'd0, "R10", "queue drained", level, 0);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule